// File: doc/BRIEF.md
# Two-Event Classification Sequence Detector

This block watches a stream of digitized port-voltage samples on a powered-device port. It recognizes the physical-layer handshake a power source uses to show that it can supply high power. Each accepted sample is sorted into a voltage band: reset, mark, gap, classification or operating. The block then follows the pattern of classification and mark events that the source applies before it turns the port on. When the source has applied two complete classification-then-mark pairs, and the port is later powered with the downstream converter running, the block pulls an active-low indicator low. Firmware on the powered side reads this indicator to learn whether it may draw high power. If the indicator stays high, that firmware has to negotiate power by other means.

Samples arrive through a valid/ready stream of unsigned millivolt values. The block never applies back-pressure: ready is held high at all times, and a sample counts on every clock edge where valid is high. Between samples, valid may stay low for any number of cycles. Those idle cycles neither advance nor break the noise filter. A plain qualifier input says when the port is powered and the converter is running. A 2-bit saturating count of recognized mark events is brought out for debug.

Top module: `twoev_class_detector`

## Requirements
- R1: Band decoding of a sample value v in mV: v < 5400 is reset band; 5400 <= v <= 9700 is mark band; 9700 < v < 13000 is gap; 13000 <= v <= 20500 is classification band; v > 20500 is operating band. An accepted gap or operating band leaves the mark count and the indicator unchanged.
- R2: A band is accepted only after RUN_LEN consecutive valid samples (default 4) fall in that band. A sample in another band restarts the run. Cycles with valid low neither add to the run nor break it.
- R3: An accepted mark band raises mark_cnt by one only if a classification band was accepted after the most recent counted mark. Otherwise it changes nothing. mark_cnt saturates at 2, so three or more pairs give 2.
- R4: An accepted reset band clears mark_cnt to 0, forgets any pending classification, and deasserts the indicator.
- R5: hp_n goes low only when mark_cnt equals 2 and pwr_run is high. It reacts one cycle after both conditions hold, and stays high when fewer than two pairs were seen.
- R6: Once low, hp_n stays low until an accepted reset band or pwr_run going low. It returns high one cycle after pwr_run falls.
- R7: smp_ready is 1 in every cycle.
- R8: After a synchronous reset, hp_n is 1 and mark_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_mv | input | MV_W | Port voltage sample in millivolts, unsigned |
| smp_ready | output | 1 | Sample accept, always high |
| pwr_run | input | 1 | Port powered and converter running |
| hp_n | output | 1 | Active-low high-power source indicator |
| mark_cnt | output | 2 | Saturating count of recognized mark events |

## Verification
The hardest case to reach from the ports is a valid-looking sequence that must be rejected. Examples are a dip into the reset band between the two pairs, a classification run that is one sample too short, or a classification that was never accepted before a mark. Each of these differs from the accepted sequence only in how long, or into which band, the voltage is held. The stimulus task therefore drives each level for an exact number of valid samples. It can hold a level for RUN_LEN-1 samples, or split a run with idle cycles, and it places values exactly on and just beyond every band edge.

// File: rtl/twoev_pkg.sv
package twoev_pkg;
  typedef enum logic [2:0] {
    BAND_RST  = 3'd0,
    BAND_MARK = 3'd1,
    BAND_GAP  = 3'd2,
    BAND_CLS  = 3'd3,
    BAND_OPER = 3'd4
  } band_e;
endpackage

// File: rtl/twoev_band_slicer.sv
module twoev_band_slicer
  import twoev_pkg::*;
#(
  parameter int MV_W     = 16,
  parameter int RST_BELOW = 5400,
  parameter int MARK_TOP  = 9700,
  parameter int CLS_BOT   = 13000,
  parameter int CLS_TOP   = 20500
) (
  input  logic [MV_W-1:0] mv,
  output band_e           band
);
  always_comb begin
    if (mv < MV_W'(RST_BELOW))       band = BAND_RST;
    else if (mv <= MV_W'(MARK_TOP))  band = BAND_MARK;
    else if (mv < MV_W'(CLS_BOT))    band = BAND_GAP;
    else if (mv <= MV_W'(CLS_TOP))   band = BAND_CLS;
    else                             band = BAND_OPER;
  end
endmodule

// File: rtl/twoev_debounce.sv
module twoev_debounce
  import twoev_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  in_valid,
  input  band_e in_band,
  output logic  acc_stb,
  output band_e acc_band
);
  localparam int CW = $clog2(RUN_LEN + 1);

  band_e         cand;
  logic [CW-1:0] run;
  logic [CW-1:0] nxt_run;

  always_comb begin
    if (in_band != cand)              nxt_run = CW'(1);
    else if (run == CW'(RUN_LEN))     nxt_run = run;
    else                              nxt_run = run + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cand     <= BAND_RST;
      run      <= '0;
      acc_band <= BAND_RST;
      acc_stb  <= 1'b0;
    end else begin
      acc_stb <= 1'b0;
      if (in_valid) begin
        cand <= in_band;
        run  <= nxt_run;
        if (nxt_run == CW'(RUN_LEN) && in_band != acc_band) begin
          acc_band <= in_band;
          acc_stb  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/twoev_sequencer.sv
module twoev_sequencer
  import twoev_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_stb,
  input  band_e      acc_band,
  input  logic       pwr_run,
  output logic [1:0] mark_cnt,
  output logic       flag
);
  logic cls_seen;
  logic wipe;

  assign wipe = acc_stb && (acc_band == BAND_RST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cls_seen <= 1'b0;
      mark_cnt <= 2'd0;
    end else if (acc_stb) begin
      case (acc_band)
        BAND_RST: begin
          cls_seen <= 1'b0;
          mark_cnt <= 2'd0;
        end
        BAND_CLS: cls_seen <= 1'b1;
        BAND_MARK: if (cls_seen) begin
          cls_seen <= 1'b0;
          mark_cnt <= (mark_cnt == 2'd2) ? 2'd2 : mark_cnt + 2'd1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    flag <= 1'b0;
    else if (wipe || !pwr_run)  flag <= 1'b0;
    else if (mark_cnt == 2'd2)  flag <= 1'b1;
  end
endmodule

// File: rtl/twoev_class_detector.sv
module twoev_class_detector
  import twoev_pkg::*;
#(
  parameter int MV_W      = 16,
  parameter int RUN_LEN   = 4,
  parameter int RST_BELOW = 5400,
  parameter int MARK_TOP  = 9700,
  parameter int CLS_BOT   = 13000,
  parameter int CLS_TOP   = 20500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_valid,
  input  logic [MV_W-1:0] smp_mv,
  output logic            smp_ready,
  input  logic            pwr_run,
  output logic            hp_n,
  output logic [1:0]      mark_cnt
);
  band_e raw_band;
  band_e acc_band;
  logic  acc_stb;
  logic  flag;

  assign smp_ready = 1'b1;

  twoev_band_slicer #(
    .MV_W(MV_W), .RST_BELOW(RST_BELOW), .MARK_TOP(MARK_TOP),
    .CLS_BOT(CLS_BOT), .CLS_TOP(CLS_TOP)
  ) u_slice (
    .mv(smp_mv), .band(raw_band)
  );

  twoev_debounce #(.RUN_LEN(RUN_LEN)) u_deb (
    .clk(clk), .rst(rst), .in_valid(smp_valid), .in_band(raw_band),
    .acc_stb(acc_stb), .acc_band(acc_band)
  );

  twoev_sequencer u_seq (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_band(acc_band),
    .pwr_run(pwr_run), .mark_cnt(mark_cnt), .flag(flag)
  );

  assign hp_n = ~flag;
endmodule

// File: rtl/twoev_class_detector_chk.sv
module twoev_class_detector_chk (
  input logic       clk,
  input logic       rst,
  input logic       smp_valid,
  input logic       smp_ready,
  input logic       pwr_run,
  input logic       hp_n,
  input logic [1:0] mark_cnt
);
  a_r7_always_ready: assert property (@(posedge clk) smp_ready);

  a_r8_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (hp_n && mark_cnt == 2'd0));

  a_r3_saturates: assert property (@(posedge clk) disable iff (rst)
    mark_cnt != 2'd3);

  a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
    (mark_cnt != $past(mark_cnt)) |->
      (mark_cnt == $past(mark_cnt) + 2'd1 || mark_cnt == 2'd0));

  a_r2_needs_sample: assert property (@(posedge clk) disable iff (rst)
    (mark_cnt != $past(mark_cnt)) |-> $past(smp_valid, 2));

  a_r5_low_needs_two: assert property (@(posedge clk) disable iff (rst)
    !hp_n |-> (mark_cnt == 2'd2));

  a_r6_low_needs_power: assert property (@(posedge clk) disable iff (rst)
    !hp_n |-> $past(pwr_run));
endmodule

bind twoev_class_detector twoev_class_detector_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .pwr_run(pwr_run), .hp_n(hp_n), .mark_cnt(mark_cnt)
);

// File: tb/twoev_class_detector_bench.sv
module twoev_class_detector_bench;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_mv = '0;
  logic        smp_ready;
  logic        pwr_run = 1'b0;
  logic        hp_n;
  logic [1:0]  mark_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twoev_class_detector u_twoev_class_detector (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .smp_ready(smp_ready), .pwr_run(pwr_run), .hp_n(hp_n), .mark_cnt(mark_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int mv, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_mv = 16'(mv);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    settle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    pwr_run = 1'b0;
    smp_valid = 1'b0;
    settle(2);
    rst = 1'b0;
    settle(1);
  endtask

  task automatic pair(int cls_mv, int mark_mv);
    send(cls_mv, N);
    send(mark_mv, N);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R8 hp_n after reset", hp_n, 1);
    chk("R8 mark_cnt after reset", mark_cnt, 0);
    chk("R7 ready", smp_ready, 1);
  endtask

  task automatic t_full_sequence();
    do_reset();
    pair(16000, 7000);
    chk("R3 one pair", mark_cnt, 1);
    pair(16000, 7000);
    chk("R3 two pairs", mark_cnt, 2);
    chk("R5 no power keeps high", hp_n, 1);
    pwr_run = 1'b1;
    settle(2);
    chk("R5 asserted with power", hp_n, 0);
    send(40000, N);
    chk("R1 operating band keeps count", mark_cnt, 2);
    chk("R1 operating band keeps flag", hp_n, 0);
    send(11000, N);
    chk("R1 gap keeps flag", hp_n, 0);
    @(negedge clk);
    pwr_run = 1'b0;
    @(negedge clk);
    chk("R6 release one cycle after power drop", hp_n, 1);
    chk("R7 ready", smp_ready, 1);
  endtask

  task automatic t_one_event();
    do_reset();
    pair(16000, 7000);
    pwr_run = 1'b1;
    settle(3);
    chk("R5 single event count", mark_cnt, 1);
    chk("R5 single event stays high", hp_n, 1);
  endtask

  task automatic t_skipped_class();
    do_reset();
    send(7000, N);
    send(3000, N);
    send(7000, N);
    chk("R3 mark without class ignored", mark_cnt, 0);
  endtask

  task automatic t_reset_between();
    do_reset();
    pair(16000, 7000);
    send(3000, N);
    chk("R4 reset band clears", mark_cnt, 0);
    pair(16000, 7000);
    pwr_run = 1'b1;
    settle(3);
    chk("R4 voided sequence count", mark_cnt, 1);
    chk("R4 voided sequence flag", hp_n, 1);
  endtask

  task automatic t_three_pairs();
    do_reset();
    pair(16000, 7000);
    pair(16000, 7000);
    pair(16000, 7000);
    chk("R3 saturates at two", mark_cnt, 2);
    pwr_run = 1'b1;
    settle(3);
    chk("R5 three pairs flag", hp_n, 0);
    send(5399, N);
    chk("R4 reset band drops flag", hp_n, 1);
    chk("R4 reset band drops count", mark_cnt, 0);
  endtask

  task automatic t_debounce();
    do_reset();
    send(16000, N - 1);
    send(7000, N);
    chk("R2 short class run rejected", mark_cnt, 0);
    send(16000, N - 1);
    settle(5);
    send(16000, 1);
    send(7000, N);
    chk("R2 idle cycles keep run", mark_cnt, 1);
    send(16000, N - 1);
    send(11000, 1);
    send(16000, 1);
    send(7000, N);
    chk("R2 interrupted run rejected", mark_cnt, 1);
  endtask

  task automatic t_edges();
    do_reset();
    pair(20500, 9700);
    chk("R1 class top and mark top inclusive", mark_cnt, 1);
    pair(13000, 5400);
    chk("R1 class bottom and mark bottom inclusive", mark_cnt, 2);
    do_reset();
    send(12999, N);
    send(7000, N);
    chk("R1 12999 is gap", mark_cnt, 0);
    send(20501, N);
    send(7000, N);
    chk("R1 20501 is operating", mark_cnt, 0);
    send(16000, N);
    send(9701, N);
    chk("R1 9701 is gap", mark_cnt, 0);
    send(7000, N);
    chk("R1 gap between class and mark tolerated", mark_cnt, 1);
  endtask

  initial begin
    t_reset_state();
    t_full_sequence();
    t_one_event();
    t_skipped_class();
    t_reset_between();
    t_three_pairs();
    t_debounce();
    t_edges();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule